// File: doc/BRIEF.md
# Coprocessor Shared-RAM Mailbox Window

This block gives a host processor a small byte-wide register window onto a RAM that it shares with an I/O coprocessor. The host can load a 16-bit pointer into the shared RAM, one byte at a time. It can then read or write RAM bytes through a data register. When auto-increment is enabled, the pointer advances after every data access, so whole message buffers can be streamed through a single register. A status/control register holds several things:

- the coprocessor's run/reset control,
- a doorbell interrupt from the host to the coprocessor,
- two write-one-to-clear interrupt flags raised by the coprocessor toward the host.

The coprocessor has its own port into the same RAM. That port is only active while the coprocessor is running. Through it the coprocessor raises the host flags and acknowledges the doorbell.

Software treats the RAM as two mailbox areas, one for sending and one for receiving. Each area has seven channels. Each channel has one handshake byte and a 32-byte message buffer. A channel's handshake byte steps through idle, new, received and complete. The host posts a message by filling the buffer, setting the handshake byte to new, and ringing the doorbell. The coprocessor answers by moving the byte to received and then to complete, and by raising a host flag.

The host port is a valid/ready request channel with a valid/ready read-response channel. A request is accepted only when `h_req_ready` is high. A read response is held until the host takes it. While an untaken response is pending, no new request is accepted. The coprocessor port is also valid/ready. Its ready is the run bit, so a coprocessor held in reset exerts back-pressure forever.

Top module: `cop_mailbox_window`

## Requirements
- R1: After reset the status byte reads 0x00, the pointer reads 0x0000, `host_irq`, `cop_run` and `cop_irq` are low, and `h_req_ready` is high.
- R2: The register offset is decoded from `h_req_offset[3:1]` only, so bit 0 is ignored:
  - 0 selects pointer high byte,
  - 2 selects pointer low byte,
  - 4 selects status,
  - 8 selects data.
  Any other offset reads 0x00 and a write to it changes nothing.
- R3: Status bit layout:
  - bit 0 is a stored bypass select with no other effect,
  - bit 1 enables auto-increment,
  - bit 2 is run and drives `cop_run`,
  - bit 3 is the host-to-coprocessor doorbell, and `cop_irq` equals bit 3 AND bit 2,
  - bits 6 and 7 always read 0.
- R4: A data access reads or writes RAM at the pointer modulo `RAM_DEPTH`. With bit 1 set, the 16-bit pointer advances by one after each data access and wraps from 0xFFFF to 0x0000. With bit 1 clear, the pointer does not move.
- R5: Status bits 4 and 5 are cleared by a host write of 1 to the same bit; a host write of 0 to them has no effect. `host_irq` is the OR of bits 4 and 5.
- R6: `c_ready` equals the run bit. While run is 0, coprocessor RAM writes, flag sets and doorbell acknowledges have no effect.
- R7: While running, the coprocessor sets bit 4 or 5 with `c_flag_set[0]` or `c_flag_set[1]`, and clears bit 3 with `c_irq_ack`. If the host writes the same status bit in the same cycle, the coprocessor action wins.
- R8: An accepted host read produces `h_rsp_valid` on the next cycle. The data stays stable until `h_rsp_ready` is high. `h_req_ready` is low while a response is pending and not being taken.
- R9: An accepted coprocessor read returns `c_rdata` with `c_rvalid` one cycle later. When both ports write the same RAM byte in the same cycle, the coprocessor's byte is kept.
- R10: Mailbox layout, for channel n from 0 to 6:
  - send area: handshake byte at 0x0201+n, buffer at 0x0220+32n,
  - receive area: handshake byte at 0x0301+n, buffer at 0x0320+32n.
  Handshake codes are 0 idle, 1 new, 2 received and 3 complete. Bytes written by either port at these addresses read back through the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req_valid | input | 1 | Host request valid |
| h_req_ready | output | 1 | Host request accepted this cycle when high |
| h_req_write | input | 1 | 1 write, 0 read |
| h_req_offset | input | 4 | Register byte offset (bit 0 ignored) |
| h_req_wdata | input | 8 | Host write byte |
| h_rsp_valid | output | 1 | Host read response valid |
| h_rsp_ready | input | 1 | Host takes the response |
| h_rsp_data | output | 8 | Host read byte |
| host_irq | output | 1 | Interrupt to host (OR of flags) |
| cop_run | output | 1 | Coprocessor run (low holds it in reset) |
| cop_irq | output | 1 | Doorbell interrupt to coprocessor |
| c_valid | input | 1 | Coprocessor RAM request valid |
| c_ready | output | 1 | Coprocessor request accepted (equals run) |
| c_write | input | 1 | Coprocessor 1 write, 0 read |
| c_addr | input | 16 | Coprocessor RAM address (modulo depth) |
| c_wdata | input | 8 | Coprocessor write byte |
| c_rvalid | output | 1 | Coprocessor read data valid |
| c_rdata | output | 8 | Coprocessor read byte |
| c_flag_set | input | 2 | Set host flag bits 4/5 (while running) |
| c_irq_ack | input | 1 | Clear doorbell bit 3 (while running) |

## Verification
The assertions take for granted that the flag-set and acknowledge inputs are single-cycle actions from a running coprocessor, and that the host holds a request stable until it is accepted. The response checks also rely on the host asserting `h_rsp_ready` eventually. The bench drives every request for exactly one cycle, at a point where `h_req_ready` is known to be high. Back-pressure is exercised only in one directed window, and that window ends by raising `h_rsp_ready`. Random traffic keeps run set, so coprocessor requests are always accepted there. The gated, run-low behaviour is covered by directed steps only.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
  localparam int PTR_W     = 16;
  localparam int BYTE_W    = 8;
  localparam int OFS_W     = 4;
  localparam int CHANNELS  = 7;
  localparam int MSG_BYTES = 32;

  // status bit positions
  localparam int ST_BYPASS = 0;
  localparam int ST_AUTOINC = 1;
  localparam int ST_RUN    = 2;
  localparam int ST_DOORBELL = 3;
  localparam int ST_FLAG0  = 4;
  localparam int FLAG_N    = 2;
  localparam int CTL_N     = 4;

  // mailbox areas
  localparam logic [PTR_W-1:0] TX_AREA = 16'h0200;
  localparam logic [PTR_W-1:0] RX_AREA = 16'h0300;
  localparam logic [PTR_W-1:0] HS_OFS  = 16'h0001;
  localparam logic [PTR_W-1:0] BUF_OFS = 16'h0020;

  typedef enum logic [BYTE_W-1:0] {
    HS_IDLE  = 8'd0,
    HS_NEW   = 8'd1,
    HS_TAKEN = 8'd2,
    HS_DONE  = 8'd3
  } hs_code_e;

  typedef enum logic [2:0] {
    SEL_PTR_HI, SEL_PTR_LO, SEL_STATUS, SEL_DATA, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [OFS_W-1:0] ofs);
    case (ofs[OFS_W-1:1])
      3'd0:    return SEL_PTR_HI;
      3'd1:    return SEL_PTR_LO;
      3'd2:    return SEL_STATUS;
      3'd4:    return SEL_DATA;
      default: return SEL_NONE;
    endcase
  endfunction

  function automatic logic [PTR_W-1:0] hs_addr(input logic [PTR_W-1:0] area, input int ch);
    return area + HS_OFS + PTR_W'(ch);
  endfunction

  function automatic logic [PTR_W-1:0] buf_addr(input logic [PTR_W-1:0] area, input int ch);
    return area + BUF_OFS + PTR_W'(ch * MSG_BYTES);
  endfunction
endpackage

// File: rtl/cmb_ctrl_reg.sv
module cmb_ctrl_reg
  import cmb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic [FLAG_N-1:0] cop_flag_set,
  input  logic              cop_irq_ack,
  output logic [BYTE_W-1:0] stat_byte,
  output logic              run,
  output logic              autoinc,
  output logic              doorbell,
  output logic [FLAG_N-1:0] flags
);
  logic [CTL_N-1:0]  ctl_q;
  logic [FLAG_N-1:0] flag_q;

  assign run      = ctl_q[ST_RUN];
  assign autoinc  = ctl_q[ST_AUTOINC];
  assign doorbell = ctl_q[ST_DOORBELL];
  assign flags    = flag_q;
  assign stat_byte = {{(BYTE_W-FLAG_N-CTL_N){1'b0}}, flag_q, ctl_q};

  // control bits: host writes them, a running coprocessor may drop the doorbell
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      if (host_wr) ctl_q <= host_wdata[CTL_N-1:0];
      if (run && cop_irq_ack) ctl_q[ST_DOORBELL] <= 1'b0;
    end
  end

  // one write-one-to-clear cell per flag; the coprocessor set is applied last
  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag_q[g] <= 1'b0;
      end else begin
        if (host_wr && host_wdata[ST_FLAG0+g]) flag_q[g] <= 1'b0;
        if (run && cop_flag_set[g])            flag_q[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmb_addr_ptr.sv
module cmb_addr_ptr
  import cmb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_hi,
  input  logic              load_lo,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              step,
  output logic [PTR_W-1:0]  ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load_hi) begin
      ptr[PTR_W-1:BYTE_W] <= load_byte;
    end else if (load_lo) begin
      ptr[BYTE_W-1:0] <= load_byte;
    end else if (step) begin
      ptr <= ptr + PTR_W'(1);
    end
  end
endmodule

// File: rtl/cmb_dpram.sv
module cmb_dpram #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             a_en,
  input  logic             a_we,
  input  logic [AW-1:0]    a_addr,
  input  logic [WIDTH-1:0] a_wdata,
  output logic [WIDTH-1:0] a_q,
  input  logic             b_en,
  input  logic             b_we,
  input  logic [AW-1:0]    b_addr,
  input  logic [WIDTH-1:0] b_wdata,
  output logic [WIDTH-1:0] b_q
);
  logic [WIDTH-1:0] mem [DEPTH];

  // port B is written last so it keeps a same-address collision
  always_ff @(posedge clk) begin
    if (a_en && a_we) mem[a_addr] <= a_wdata;
    if (b_en && b_we) mem[b_addr] <= b_wdata;
  end

  // read outputs only move on a read, so a held response stays stable
  always_ff @(posedge clk) begin
    if (a_en && !a_we) a_q <= mem[a_addr];
    if (b_en && !b_we) b_q <= mem[b_addr];
  end
endmodule

// File: rtl/cop_mailbox_window.sv
module cop_mailbox_window
  import cmb_pkg::*;
#(
  parameter int RAM_DEPTH = 1024,
  localparam int RAM_AW   = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_req_valid,
  output logic              h_req_ready,
  input  logic              h_req_write,
  input  logic [OFS_W-1:0]  h_req_offset,
  input  logic [BYTE_W-1:0] h_req_wdata,
  output logic              h_rsp_valid,
  input  logic              h_rsp_ready,
  output logic [BYTE_W-1:0] h_rsp_data,
  output logic              host_irq,
  output logic              cop_run,
  output logic              cop_irq,
  input  logic              c_valid,
  output logic              c_ready,
  input  logic              c_write,
  input  logic [PTR_W-1:0]  c_addr,
  input  logic [BYTE_W-1:0] c_wdata,
  output logic              c_rvalid,
  output logic [BYTE_W-1:0] c_rdata,
  input  logic [FLAG_N-1:0] c_flag_set,
  input  logic              c_irq_ack
);
  reg_sel_e          sel;
  logic              acc, rd_acc, wr_acc, data_acc, c_acc;
  logic [PTR_W-1:0]  ptr;
  logic [BYTE_W-1:0] stat_byte, reg_byte, ram_a_q;
  logic              run, autoinc, doorbell;
  logic [FLAG_N-1:0] flags;
  logic              rsp_valid_q, rsp_from_ram_q;
  logic [BYTE_W-1:0] rsp_reg_q;

  assign sel      = decode_offset(h_req_offset);
  assign acc      = h_req_valid && h_req_ready;
  assign wr_acc   = acc && h_req_write;
  assign rd_acc   = acc && !h_req_write;
  assign data_acc = acc && (sel == SEL_DATA);
  assign c_ready  = run;
  assign c_acc    = c_valid && c_ready;

  cmb_ctrl_reg u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr      (wr_acc && (sel == SEL_STATUS)),
    .host_wdata   (h_req_wdata),
    .cop_flag_set (c_flag_set),
    .cop_irq_ack  (c_irq_ack),
    .stat_byte    (stat_byte),
    .run          (run),
    .autoinc      (autoinc),
    .doorbell     (doorbell),
    .flags        (flags)
  );

  cmb_addr_ptr u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_hi   (wr_acc && (sel == SEL_PTR_HI)),
    .load_lo   (wr_acc && (sel == SEL_PTR_LO)),
    .load_byte (h_req_wdata),
    .step      (data_acc && autoinc),
    .ptr       (ptr)
  );

  cmb_dpram #(.DEPTH(RAM_DEPTH), .WIDTH(BYTE_W)) u_ram (
    .clk     (clk),
    .a_en    (data_acc),
    .a_we    (h_req_write),
    .a_addr  (ptr[RAM_AW-1:0]),
    .a_wdata (h_req_wdata),
    .a_q     (ram_a_q),
    .b_en    (c_acc),
    .b_we    (c_write),
    .b_addr  (c_addr[RAM_AW-1:0]),
    .b_wdata (c_wdata),
    .b_q     (c_rdata)
  );

  always_comb begin
    case (sel)
      SEL_PTR_HI: reg_byte = ptr[PTR_W-1:BYTE_W];
      SEL_PTR_LO: reg_byte = ptr[BYTE_W-1:0];
      SEL_STATUS: reg_byte = stat_byte;
      default:    reg_byte = '0;
    endcase
  end

  // response channel: one entry, held until taken
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q    <= 1'b0;
      rsp_from_ram_q <= 1'b0;
      rsp_reg_q      <= '0;
    end else if (rd_acc) begin
      rsp_valid_q    <= 1'b1;
      rsp_from_ram_q <= (sel == SEL_DATA);
      rsp_reg_q      <= reg_byte;
    end else if (h_rsp_ready) begin
      rsp_valid_q    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) c_rvalid <= 1'b0;
    else        c_rvalid <= c_acc && !c_write;
  end

  assign h_req_ready = !rsp_valid_q || h_rsp_ready;
  assign h_rsp_valid = rsp_valid_q;
  assign h_rsp_data  = rsp_from_ram_q ? ram_a_q : rsp_reg_q;
  assign host_irq    = |flags;
  assign cop_run     = run;
  assign cop_irq     = doorbell && run;
endmodule

// File: rtl/cop_mailbox_window_chk.sv
module cop_mailbox_window_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       h_req_valid,
  input logic       h_req_ready,
  input logic       h_req_write,
  input logic       h_rsp_valid,
  input logic       h_rsp_ready,
  input logic [7:0] h_rsp_data,
  input logic       host_irq,
  input logic       cop_run,
  input logic       cop_irq,
  input logic       c_valid,
  input logic       c_ready,
  input logic       c_write,
  input logic       c_rvalid,
  input logic [1:0] c_flag_set,
  input logic       c_irq_ack
);
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    h_rsp_valid && !h_rsp_ready |=> h_rsp_valid && $stable(h_rsp_data)); // R8
  AST_NO_ACCEPT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    h_rsp_valid && !h_rsp_ready |-> !h_req_ready); // R8
  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    h_req_valid && h_req_ready && !h_req_write |=> h_rsp_valid); // R8
  AST_HALTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cop_run |-> !c_ready && !cop_irq); // R6
  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cop_run && (c_flag_set != 2'b00) |=> host_irq); // R7
  AST_ACK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cop_run && c_irq_ack |=> !cop_irq); // R7
  AST_COP_READ_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid && c_ready && !c_write |=> c_rvalid); // R9
endmodule

bind cop_mailbox_window cop_mailbox_window_chk u_chk (
  .clk(clk), .rst_n(rst_n), .h_req_valid(h_req_valid), .h_req_ready(h_req_ready),
  .h_req_write(h_req_write), .h_rsp_valid(h_rsp_valid), .h_rsp_ready(h_rsp_ready),
  .h_rsp_data(h_rsp_data), .host_irq(host_irq), .cop_run(cop_run), .cop_irq(cop_irq),
  .c_valid(c_valid), .c_ready(c_ready), .c_write(c_write), .c_rvalid(c_rvalid),
  .c_flag_set(c_flag_set), .c_irq_ack(c_irq_ack)
);

// File: tb/tb_cop_mailbox_window.sv
module tb_cop_mailbox_window;
  import cmb_pkg::*;
  localparam int DEPTH = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic h_req_valid = 0, h_req_write = 0, h_rsp_ready = 1;
  logic [3:0] h_req_offset = 0;
  logic [7:0] h_req_wdata = 0;
  logic h_req_ready, h_rsp_valid, host_irq, cop_run, cop_irq, c_ready, c_rvalid;
  logic [7:0] h_rsp_data, c_rdata;
  logic c_valid = 0, c_write = 0, c_irq_ack = 0;
  logic [15:0] c_addr = 0;
  logic [7:0] c_wdata = 0;
  logic [1:0] c_flag_set = 0;

  int n_chk = 0, n_fail = 0;
  logic [7:0] ref_mem [DEPTH];
  logic [15:0] ref_ptr;

  always #10 clk = ~clk;

  cop_mailbox_window #(.RAM_DEPTH(DEPTH)) dut (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fill_val(input int i);
    return 8'((i * 7 + 3) ^ (i >> 3));
  endfunction

  task automatic hwr(input logic [3:0] ofs, input logic [7:0] d);
    @(negedge clk);
    h_req_valid = 1; h_req_write = 1; h_req_offset = ofs; h_req_wdata = d;
    @(negedge clk);
    h_req_valid = 0; h_req_write = 0;
  endtask

  task automatic hrd(input logic [3:0] ofs, output logic [7:0] d);
    @(negedge clk);
    h_req_valid = 1; h_req_write = 0; h_req_offset = ofs;
    @(negedge clk);
    h_req_valid = 0;
    if (!h_rsp_valid) chk("R8 rsp_valid after read", 16'(h_rsp_valid), 16'd1);
    d = h_rsp_data;
  endtask

  task automatic cwr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    c_valid = 1; c_write = 1; c_addr = a; c_wdata = d;
    @(negedge clk);
    c_valid = 0; c_write = 0;
  endtask

  task automatic crd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    c_valid = 1; c_write = 0; c_addr = a;
    @(negedge clk);
    c_valid = 0;
    chk("R9 c_rvalid one cycle after read", 16'(c_rvalid), 16'd1);
    d = c_rdata;
  endtask

  task automatic set_ptr(input logic [15:0] p);
    hwr(4'd0, p[15:8]);
    hwr(4'd2, p[7:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 h_req_ready", 16'(h_req_ready), 16'd1);
    chk("R1 host_irq", 16'(host_irq), 16'd0);
    chk("R1 cop_run", 16'(cop_run), 16'd0);
    chk("R1 cop_irq", 16'(cop_irq), 16'd0);
    hrd(4'd4, d); chk("R1 status", 16'(d), 16'h00);
    hrd(4'd0, d); chk("R1 ptr hi", 16'(d), 16'h00);
    hrd(4'd2, d); chk("R1 ptr lo", 16'(d), 16'h00);

    // R2 decode with bit 0 ignored
    hwr(4'd1, 8'h12); hwr(4'd3, 8'h34);
    hrd(4'd0, d); chk("R2 odd offset 1 hits ptr hi", 16'(d), 16'h12);
    hrd(4'd2, d); chk("R2 odd offset 3 hits ptr lo", 16'(d), 16'h34);
    hwr(4'd6, 8'hFF); hwr(4'd12, 8'hFF);
    hrd(4'd6, d);  chk("R2 unmapped offset reads 0", 16'(d), 16'h00);
    hrd(4'd5, d);  chk("R2 unmapped write no effect on status", 16'(d), 16'h00);
    hrd(4'd1, d);  chk("R2 unmapped write no effect on ptr", 16'(d), 16'h12);

    // R6 run low: coprocessor gated
    hwr(4'd4, 8'h00);
    set_ptr(16'h0005); hwr(4'd8, 8'h11);
    chk("R6 c_ready low while halted", 16'(c_ready), 16'd0);
    cwr(16'h0005, 8'h99);
    @(negedge clk); c_flag_set = 2'b11; @(negedge clk); c_flag_set = 0;
    chk("R6 flag set ignored while halted", 16'(host_irq), 16'd0);
    set_ptr(16'h0005); hrd(4'd9, d);
    chk("R6 cop write ignored while halted", 16'(d), 16'h11);

    // R3 layout
    hwr(4'd4, 8'hC9);
    hrd(4'd4, d); chk("R3 bits 6/7 read 0, bypass and doorbell kept", 16'(d), 16'h09);
    chk("R3 cop_irq needs run", 16'(cop_irq), 16'd0);
    hwr(4'd4, 8'h0C);
    chk("R3 cop_run", 16'(cop_run), 16'd1);
    chk("R3 cop_irq", 16'(cop_irq), 16'd1);

    // R7 ack vs host write same cycle
    @(negedge clk);
    h_req_valid = 1; h_req_write = 1; h_req_offset = 4'd4; h_req_wdata = 8'h0E; c_irq_ack = 1;
    @(negedge clk);
    h_req_valid = 0; h_req_write = 0; c_irq_ack = 0;
    hrd(4'd4, d); chk("R7 ack beats host doorbell write", 16'(d), 16'h06);
    @(negedge clk); c_flag_set = 2'b10; @(negedge clk); c_flag_set = 0;
    chk("R5 host_irq from flag bit 5", 16'(host_irq), 16'd1);
    hrd(4'd4, d); chk("R7 flag bit 5 set", 16'(d), 16'h26);
    hwr(4'd4, 8'h06);
    hrd(4'd4, d); chk("R5 writing 0 keeps flag", 16'(d), 16'h26);
    hwr(4'd4, 8'h26);
    chk("R5 W1C clears host_irq", 16'(host_irq), 16'd0);
    @(negedge clk); c_flag_set = 2'b01; @(negedge clk); c_flag_set = 0;
    @(negedge clk);
    h_req_valid = 1; h_req_write = 1; h_req_offset = 4'd4; h_req_wdata = 8'h16; c_flag_set = 2'b01;
    @(negedge clk);
    h_req_valid = 0; h_req_write = 0; c_flag_set = 0;
    hrd(4'd4, d); chk("R7 set beats host W1C", 16'(d), 16'h16);
    hwr(4'd4, 8'h16);
    chk("R5 bit 4 cleared", 16'(host_irq), 16'd0);

    // fill RAM with autoincrement, build the reference
    set_ptr(16'h0000);
    for (int i = 0; i < DEPTH; i++) begin
      hwr(4'd8, fill_val(i)); ref_mem[i] = fill_val(i);
    end
    hrd(4'd0, d); chk("R4 ptr advanced hi", 16'(d), 16'(DEPTH >> 8));
    ref_ptr = 16'(DEPTH);

    // R4 wrap 0xFFFF -> 0x0000 and aliasing
    set_ptr(16'hFFFF); hwr(4'd8, 8'hAB); ref_mem[DEPTH-1] = 8'hAB;
    hrd(4'd0, d); chk("R4 wrap hi", 16'(d), 16'h00);
    hrd(4'd2, d); chk("R4 wrap lo", 16'(d), 16'h00);
    set_ptr(16'h07FF); hrd(4'd8, d); chk("R4 modulo depth alias", 16'(d), 16'hAB);
    hwr(4'd4, 8'h04);
    set_ptr(16'h0010); hrd(4'd8, d); hrd(4'd8, d);
    hrd(4'd2, d); chk("R4 no step without autoinc", 16'(d), 16'h10);

    // R8 back-pressure
    @(negedge clk); h_rsp_ready = 0;
    h_req_valid = 1; h_req_offset = 4'd8;
    @(negedge clk); h_req_valid = 0;
    repeat (3) begin
      @(negedge clk);
      chk("R8 held valid", 16'(h_rsp_valid), 16'd1);
      chk("R8 ready low while pending", 16'(h_req_ready), 16'd0);
      chk("R8 held data", 16'(h_rsp_data), 16'(ref_mem[16]));
    end
    h_rsp_ready = 1;
    @(negedge clk);
    chk("R8 response taken", 16'(h_rsp_valid), 16'd0);

    // R9 collision
    hwr(4'd4, 8'h06);
    set_ptr(16'h0040);
    @(negedge clk);
    h_req_valid = 1; h_req_write = 1; h_req_offset = 4'd8; h_req_wdata = 8'h55;
    c_valid = 1; c_write = 1; c_addr = 16'h0040; c_wdata = 8'hAA;
    @(negedge clk);
    h_req_valid = 0; h_req_write = 0; c_valid = 0; c_write = 0;
    ref_mem[16'h40] = 8'hAA;
    crd(16'h0040, d); chk("R9 cop wins collision", 16'(d), 16'hAA);

    // random traffic against the reference
    ref_ptr = 16'h0041;
    for (int k = 0; k < 600; k++) begin
      int op;
      logic [7:0] v;
      logic [15:0] a;
      op = int'($urandom_range(0, 4));
      v = 8'($urandom);
      a = 16'($urandom);
      case (op)
        0: begin set_ptr(a); ref_ptr = a; end
        1: begin hwr(4'd8, v); ref_mem[ref_ptr % DEPTH] = v; ref_ptr++; end
        2: begin hrd(4'd8, d); chk("R4 random host read", 16'(d), 16'(ref_mem[ref_ptr % DEPTH])); ref_ptr++; end
        3: begin cwr(a, v); ref_mem[a % DEPTH] = v; end
        default: begin crd(a, d); chk("R9 random cop read", 16'(d), 16'(ref_mem[a % DEPTH])); end
      endcase
    end

    // R10 mailbox handshake on send channel 3
    set_ptr(buf_addr(TX_AREA, 3));
    for (int i = 0; i < MSG_BYTES; i++) hwr(4'd8, 8'(8'hA0 + i));
    set_ptr(hs_addr(TX_AREA, 3)); hwr(4'd8, HS_NEW);
    hwr(4'd4, 8'h0E);
    chk("R10 doorbell rung", 16'(cop_irq), 16'd1);
    crd(hs_addr(TX_AREA, 3), d); chk("R10 cop sees new", 16'(d), 16'(HS_NEW));
    for (int i = 0; i < MSG_BYTES; i++) begin
      crd(buf_addr(TX_AREA, 3) + 16'(i), d);
      chk("R10 message byte", 16'(d), 16'(8'hA0 + i));
    end
    cwr(hs_addr(TX_AREA, 3), HS_TAKEN);
    @(negedge clk); c_irq_ack = 1; @(negedge clk); c_irq_ack = 0;
    chk("R10 doorbell acked", 16'(cop_irq), 16'd0);
    set_ptr(hs_addr(TX_AREA, 3)); hrd(4'd8, d);
    chk("R10 host sees received", 16'(d), 16'(HS_TAKEN));
    cwr(hs_addr(TX_AREA, 3), HS_DONE);
    @(negedge clk); c_flag_set = 2'b01; @(negedge clk); c_flag_set = 0;
    chk("R10 host interrupted", 16'(host_irq), 16'd1);
    set_ptr(hs_addr(TX_AREA, 3)); hrd(4'd8, d);
    chk("R10 host sees complete", 16'(d), 16'(HS_DONE));
    set_ptr(hs_addr(TX_AREA, 3)); hwr(4'd8, HS_IDLE);
    hwr(4'd4, 8'h16);
    chk("R10 flag cleared", 16'(host_irq), 16'd0);
    crd(hs_addr(TX_AREA, 3), d); chk("R10 back to idle", 16'(d), 16'(HS_IDLE));
    crd(hs_addr(RX_AREA, 6), d);
    chk("R10 receive state byte", 16'(d), 16'(ref_mem[hs_addr(RX_AREA, 6) % DEPTH]));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule